// File: doc/BRIEF.md
# Dual-Port Mailbox Interrupt Controller

This block sits next to a two-port RAM and turns accesses to two reserved words at the top of the address space into one interrupt line per port. The two ports are called left and right. When the left port writes the highest word, the right port's interrupt goes active. The right port acknowledges it by reading that same word. When the right port writes the word just below it, the left port's interrupt goes active. The left port acknowledges it by reading that word. The block only watches the access strobes. The data of the mailbox words is still stored by the RAM beside it, and the RAM array is not part of this block.

Each port has an address, an active-low chip select, a read/write select (1 reads, 0 writes) and an active-low output enable. All inputs are sampled on the rising edge of `clk`. A per-port access tracker uses the states ACC_IDLE, ACC_WR_HIT and ACC_WR_MISS:
- idle to hit: a write cycle is seen to the peer's mailbox address.
- idle to miss: a write cycle is seen to any other address.
- hit to miss, or miss to hit: the address moves while the write is still active.
- hit to idle: the write ends. This transition raises the peer's interrupt.
- miss to idle: the write ends with no effect.

A per-port flag uses the states FLAG_CLEAR and FLAG_RAISED:
- clear to raised: a set request arrives.
- raised to clear: a qualifying read arrives and no set request arrives in the same cycle.

Parameter `ADDR_W` is 15 for a 32K-word array or 16 for a 64K-word array. The mailbox addresses follow from it: the top word is all ones, and the next word is all ones minus one.

Top module: `mbox_irq_ctrl`

## Requirements
- R1: While `rst_n` is low, and after it is released, both `lt_irq_n` and `rt_irq_n` are 1 (inactive).
- R2: A left write (`lt_cs_n`=0, `lt_rw_n`=0) to the top address (all ones; 0x7FFF when ADDR_W=15) drives `rt_irq_n` to 0 at the first clock edge where the write is sampled inactive. The output does not change while the write, of any length, is still active.
- R3: A right read (`rt_cs_n`=0, `rt_rw_n`=1, `rt_oe_n`=0) of the top address returns `rt_irq_n` to 1 at the edge that samples the read.
- R4: A right write to the next address (all ones minus one; 0x7FFE when ADDR_W=15) drives `lt_irq_n` to 0 at the first edge where the write is sampled inactive.
- R5: A left read with `lt_oe_n`=0 of the next address returns `lt_irq_n` to 1 at the edge that samples the read.
- R6: The following reads leave an active interrupt unchanged: a read with the output enable at 1, a read of a non-mailbox address, and a read by the other port of the acknowledging address.
- R7: Writes have no effect on either interrupt in these cases: a port writes its own acknowledge address (right writes the top word, left writes the next word), or a port writes a non-mailbox address.
- R8: If a set and a clear reach the same interrupt at the same edge, the interrupt becomes or stays active (0).
- R9: Whether a write raises an interrupt is decided by the address in the write's last active cycle. A write that moves off the mailbox address before it ends raises nothing.
- R10: With ADDR_W=16, the mailbox words are 0xFFFF and 0xFFFE, and a left write to 0x7FFF has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lt_addr | input | ADDR_W | Left port address |
| lt_cs_n | input | 1 | Left chip select, active low |
| lt_rw_n | input | 1 | Left read (1) / write (0) |
| lt_oe_n | input | 1 | Left output enable, active low |
| rt_addr | input | ADDR_W | Right port address |
| rt_cs_n | input | 1 | Right chip select, active low |
| rt_rw_n | input | 1 | Right read (1) / write (0) |
| rt_oe_n | input | 1 | Right output enable, active low |
| lt_irq_n | output | 1 | Interrupt to the left port, active low |
| rt_irq_n | output | 1 | Interrupt to the right port, active low |

## Verification
Single-cycle and multi-cycle writes to the peer's mailbox show that the set waits for the end of the write rather than its start. Reads that differ from a valid acknowledge in one qualifier each (output enable at 1, wrong address, wrong port) separate a true clear from a near miss. Writes by the owning port and writes to ordinary addresses confirm that only the correct pairing of port and address raises an interrupt. A write that ends at the same edge as the peer's acknowledge read shows that the set has priority. A write that moves its address mid-access shows that the last active cycle decides. A second instance with 16 address bits shows that the mailbox words move to the top of the larger array.

// File: rtl/mbox_pkg.sv
package mbox_pkg;

    // Per-port write tracking state
    typedef enum logic [1:0] {
        ACC_IDLE    = 2'd0,
        ACC_WR_HIT  = 2'd1,
        ACC_WR_MISS = 2'd2
    } acc_state_t;

    // Interrupt flag state
    typedef enum logic {
        FLAG_CLEAR  = 1'b0,
        FLAG_RAISED = 1'b1
    } flag_state_t;

    localparam int NUM_PORTS = 2;

endpackage

// File: rtl/mbox_access_decode.sv
module mbox_access_decode
    import mbox_pkg::*;
#(
    parameter int              ADDR_W    = 15,
    parameter logic [ADDR_W-1:0] WR_TARGET = '1,
    parameter logic [ADDR_W-1:0] RD_TARGET = '1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              cs_n,
    input  logic              rw_n,
    input  logic              oe_n,
    output logic              raise_peer,
    output logic              clear_own
);

    acc_state_t state_q, state_d;

    logic wr_now;
    logic rd_now;
    logic wr_match;

    assign wr_now   = !cs_n && !rw_n;
    assign rd_now   = !cs_n &&  rw_n && !oe_n;
    assign wr_match = (addr == WR_TARGET);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ACC_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ACC_IDLE: begin
                if (wr_now) begin
                    state_d = wr_match ? ACC_WR_HIT : ACC_WR_MISS;
                end
            end
            ACC_WR_HIT: begin
                if (!wr_now) begin
                    state_d = ACC_IDLE;
                end else if (!wr_match) begin
                    state_d = ACC_WR_MISS;
                end
            end
            ACC_WR_MISS: begin
                if (!wr_now) begin
                    state_d = ACC_IDLE;
                end else if (wr_match) begin
                    state_d = ACC_WR_HIT;
                end
            end
            default: state_d = ACC_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        raise_peer = 1'b0;
        clear_own  = rd_now && (addr == RD_TARGET);
        unique case (state_q)
            ACC_WR_HIT:  raise_peer = !wr_now;
            ACC_IDLE,
            ACC_WR_MISS: raise_peer = 1'b0;
            default:     raise_peer = 1'b0;
        endcase
    end

endmodule

// File: rtl/mbox_irq_flag.sv
module mbox_irq_flag
    import mbox_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic set_req,
    input  logic clr_req,
    output logic irq_n
);

    flag_state_t state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= FLAG_CLEAR;
        end else begin
            state_q <= state_d;
        end
    end

    // Set has priority over clear
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FLAG_CLEAR: begin
                if (set_req) state_d = FLAG_RAISED;
            end
            FLAG_RAISED: begin
                if (clr_req && !set_req) state_d = FLAG_CLEAR;
            end
            default: state_d = FLAG_CLEAR;
        endcase
    end

    always_comb begin
        unique case (state_q)
            FLAG_RAISED: irq_n = 1'b0;
            FLAG_CLEAR:  irq_n = 1'b1;
            default:     irq_n = 1'b1;
        endcase
    end

endmodule

// File: rtl/mbox_irq_ctrl.sv
module mbox_irq_ctrl
    import mbox_pkg::*;
#(
    parameter int ADDR_W = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] lt_addr,
    input  logic              lt_cs_n,
    input  logic              lt_rw_n,
    input  logic              lt_oe_n,
    input  logic [ADDR_W-1:0] rt_addr,
    input  logic              rt_cs_n,
    input  logic              rt_rw_n,
    input  logic              rt_oe_n,
    output logic              lt_irq_n,
    output logic              rt_irq_n
);

    localparam logic [ADDR_W-1:0] MBOX_TOP  = '1;
    localparam logic [ADDR_W-1:0] MBOX_NEXT = MBOX_TOP - 1'b1;

    // Index 0 = left port, index 1 = right port
    logic [NUM_PORTS-1:0][ADDR_W-1:0] addr_a;
    logic [NUM_PORTS-1:0]             cs_n_a;
    logic [NUM_PORTS-1:0]             rw_n_a;
    logic [NUM_PORTS-1:0]             oe_n_a;
    logic [NUM_PORTS-1:0]             raise_a;
    logic [NUM_PORTS-1:0]             clear_a;
    logic [NUM_PORTS-1:0]             irq_n_a;

    assign addr_a = {rt_addr, lt_addr};
    assign cs_n_a = {rt_cs_n, lt_cs_n};
    assign rw_n_a = {rt_rw_n, lt_rw_n};
    assign oe_n_a = {rt_oe_n, lt_oe_n};

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        // Left writes TOP to signal right; acknowledges by reading NEXT.
        mbox_access_decode #(
            .ADDR_W    (ADDR_W),
            .WR_TARGET ((p == 0) ? MBOX_TOP  : MBOX_NEXT),
            .RD_TARGET ((p == 0) ? MBOX_NEXT : MBOX_TOP)
        ) u_dec (
            .clk        (clk),
            .rst_n      (rst_n),
            .addr       (addr_a[p]),
            .cs_n       (cs_n_a[p]),
            .rw_n       (rw_n_a[p]),
            .oe_n       (oe_n_a[p]),
            .raise_peer (raise_a[p]),
            .clear_own  (clear_a[p])
        );

        mbox_irq_flag u_flag (
            .clk     (clk),
            .rst_n   (rst_n),
            .set_req (raise_a[NUM_PORTS-1-p]),
            .clr_req (clear_a[p]),
            .irq_n   (irq_n_a[p])
        );
    end

    assign lt_irq_n = irq_n_a[0];
    assign rt_irq_n = irq_n_a[1];

endmodule

// File: rtl/mbox_irq_ctrl_chk.sv
module mbox_irq_ctrl_chk #(
    parameter int ADDR_W = 15
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] lt_addr,
    input logic              lt_cs_n,
    input logic              lt_rw_n,
    input logic              lt_oe_n,
    input logic [ADDR_W-1:0] rt_addr,
    input logic              rt_cs_n,
    input logic              rt_rw_n,
    input logic              rt_oe_n,
    input logic              lt_irq_n,
    input logic              rt_irq_n
);

    localparam logic [ADDR_W-1:0] TOP_W  = '1;
    localparam logic [ADDR_W-1:0] NEXT_W = TOP_W - 1'b1;

    logic lt_wr, rt_wr, lt_wr_top, rt_wr_next, lt_ack, rt_ack;
    assign lt_wr      = !lt_cs_n && !lt_rw_n;
    assign rt_wr      = !rt_cs_n && !rt_rw_n;
    assign lt_wr_top  = lt_wr && (lt_addr == TOP_W);
    assign rt_wr_next = rt_wr && (rt_addr == NEXT_W);
    assign lt_ack     = !lt_cs_n && lt_rw_n && !lt_oe_n && (lt_addr == NEXT_W);
    assign rt_ack     = !rt_cs_n && rt_rw_n && !rt_oe_n && (rt_addr == TOP_W);

    assert_reset_idle_R1: assert property (@(posedge clk)
        !rst_n |=> (lt_irq_n && rt_irq_n));

    assert_rt_raise_source_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rt_irq_n) |-> ($past(lt_wr_top, 2) && !$past(lt_wr, 1)));

    assert_rt_clear_source_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rt_irq_n) |-> $past(rt_ack));

    assert_lt_raise_source_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(lt_irq_n) |-> ($past(rt_wr_next, 2) && !$past(rt_wr, 1)));

    assert_lt_clear_source_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lt_irq_n) |-> $past(lt_ack));

    assert_rt_set_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n, 2) && $past(lt_wr_top, 2) && !$past(lt_wr, 1)) |-> !rt_irq_n);

    assert_lt_set_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n, 2) && $past(rt_wr_next, 2) && !$past(rt_wr, 1)) |-> !lt_irq_n);

endmodule

bind mbox_irq_ctrl mbox_irq_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .lt_addr  (lt_addr),
    .lt_cs_n  (lt_cs_n),
    .lt_rw_n  (lt_rw_n),
    .lt_oe_n  (lt_oe_n),
    .rt_addr  (rt_addr),
    .rt_cs_n  (rt_cs_n),
    .rt_rw_n  (rt_rw_n),
    .rt_oe_n  (rt_oe_n),
    .lt_irq_n (lt_irq_n),
    .rt_irq_n (rt_irq_n)
);

// File: tb/mbox_irq_ctrl_test.sv
`timescale 1ns/1ps
module mbox_irq_ctrl_test;

    localparam logic [14:0] TOP  = 15'h7FFF;
    localparam logic [14:0] NEXT = 15'h7FFE;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    logic [14:0] lt_addr = '0, rt_addr = '0;
    logic lt_cs_n = 1'b1, lt_rw_n = 1'b1, lt_oe_n = 1'b1;
    logic rt_cs_n = 1'b1, rt_rw_n = 1'b1, rt_oe_n = 1'b1;
    logic lt_irq_n, rt_irq_n;

    logic [15:0] w_lt_addr = '0, w_rt_addr = '0;
    logic w_lt_cs_n = 1'b1, w_lt_rw_n = 1'b1, w_lt_oe_n = 1'b1;
    logic w_rt_cs_n = 1'b1, w_rt_rw_n = 1'b1, w_rt_oe_n = 1'b1;
    logic w_lt_irq_n, w_rt_irq_n;

    int n_vec = 0;
    int n_bad = 0;
    bit done = 1'b0;

    mbox_irq_ctrl #(.ADDR_W(15)) uut (
        .clk(clk), .rst_n(rst_n),
        .lt_addr(lt_addr), .lt_cs_n(lt_cs_n), .lt_rw_n(lt_rw_n), .lt_oe_n(lt_oe_n),
        .rt_addr(rt_addr), .rt_cs_n(rt_cs_n), .rt_rw_n(rt_rw_n), .rt_oe_n(rt_oe_n),
        .lt_irq_n(lt_irq_n), .rt_irq_n(rt_irq_n)
    );

    mbox_irq_ctrl #(.ADDR_W(16)) uut_wide (
        .clk(clk), .rst_n(rst_n),
        .lt_addr(w_lt_addr), .lt_cs_n(w_lt_cs_n), .lt_rw_n(w_lt_rw_n), .lt_oe_n(w_lt_oe_n),
        .rt_addr(w_rt_addr), .rt_cs_n(w_rt_cs_n), .rt_rw_n(w_rt_rw_n), .rt_oe_n(w_rt_oe_n),
        .lt_irq_n(w_lt_irq_n), .rt_irq_n(w_rt_irq_n)
    );

    task automatic check(input logic got, input logic exp, input string req, input string what);
        n_vec++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %b expected %b", req, what, got, exp);
        end
    endtask

    // Write of ncyc active cycles; returns one edge after the write is sampled inactive.
    task automatic lt_write(input logic [14:0] a, input int ncyc, input logic rt_before);
        @(negedge clk);
        lt_addr = a; lt_cs_n = 1'b0; lt_rw_n = 1'b0;
        for (int i = 0; i < ncyc; i++) begin
            @(negedge clk);
            check(rt_irq_n, rt_before, "R2", "rt_irq_n during active write");
        end
        lt_cs_n = 1'b1; lt_rw_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic rt_write(input logic [14:0] a);
        @(negedge clk);
        rt_addr = a; rt_cs_n = 1'b0; rt_rw_n = 1'b0;
        @(negedge clk);
        rt_cs_n = 1'b1; rt_rw_n = 1'b1;
        @(negedge clk);
    endtask

    // Read of one cycle; returns at the negedge after the sampling edge.
    task automatic lt_read(input logic [14:0] a, input logic oe);
        @(negedge clk);
        lt_addr = a; lt_cs_n = 1'b0; lt_rw_n = 1'b1; lt_oe_n = oe;
        @(negedge clk);
        lt_cs_n = 1'b1; lt_oe_n = 1'b1;
    endtask

    task automatic rt_read(input logic [14:0] a, input logic oe);
        @(negedge clk);
        rt_addr = a; rt_cs_n = 1'b0; rt_rw_n = 1'b1; rt_oe_n = oe;
        @(negedge clk);
        rt_cs_n = 1'b1; rt_oe_n = 1'b1;
    endtask

    task automatic t_reset_R1();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check(lt_irq_n, 1'b1, "R1", "lt_irq_n in reset");
        check(rt_irq_n, 1'b1, "R1", "rt_irq_n in reset");
        rst_n = 1'b1;
        @(negedge clk);
        check(lt_irq_n, 1'b1, "R1", "lt_irq_n after reset");
        check(rt_irq_n, 1'b1, "R1", "rt_irq_n after reset");
    endtask

    task automatic t_left_raise_R2();
        lt_write(TOP, 1, 1'b1);
        check(rt_irq_n, 1'b0, "R2", "rt_irq_n after left write to top");
        check(lt_irq_n, 1'b1, "R2", "lt_irq_n untouched");
        rt_read(TOP, 1'b0);
        check(rt_irq_n, 1'b1, "R3", "rt_irq_n after ack");
        lt_write(TOP, 3, 1'b1);
        check(rt_irq_n, 1'b0, "R2", "rt_irq_n after 3-cycle write");
    endtask

    task automatic t_bad_reads_R6();
        rt_read(TOP, 1'b1);
        check(rt_irq_n, 1'b0, "R6", "read with oe high");
        rt_read(NEXT, 1'b0);
        check(rt_irq_n, 1'b0, "R6", "right read of next");
        lt_read(TOP, 1'b0);
        check(rt_irq_n, 1'b0, "R6", "left read of top");
        rt_read(15'h0123, 1'b0);
        check(rt_irq_n, 1'b0, "R6", "right read of plain word");
    endtask

    task automatic t_right_clear_R3();
        rt_read(TOP, 1'b0);
        check(rt_irq_n, 1'b1, "R3", "rt_irq_n after right read of top");
    endtask

    task automatic t_left_path_R4_R5();
        rt_write(NEXT);
        check(lt_irq_n, 1'b0, "R4", "lt_irq_n after right write to next");
        check(rt_irq_n, 1'b1, "R4", "rt_irq_n untouched");
        lt_read(NEXT, 1'b1);
        check(lt_irq_n, 1'b0, "R6", "left read oe high");
        lt_read(NEXT, 1'b0);
        check(lt_irq_n, 1'b1, "R5", "lt_irq_n after left read of next");
    endtask

    task automatic t_owner_writes_R7();
        rt_write(TOP);
        check(rt_irq_n, 1'b1, "R7", "right writes top: rt");
        check(lt_irq_n, 1'b1, "R7", "right writes top: lt");
        lt_write(NEXT, 1, 1'b1);
        check(rt_irq_n, 1'b1, "R7", "left writes next: rt");
        check(lt_irq_n, 1'b1, "R7", "left writes next: lt");
        lt_write(15'h1234, 2, 1'b1);
        rt_write(15'h0000);
        check(rt_irq_n, 1'b1, "R7", "plain writes: rt");
        check(lt_irq_n, 1'b1, "R7", "plain writes: lt");
    endtask

    task automatic t_set_wins_R8();
        @(negedge clk);
        lt_addr = TOP; lt_cs_n = 1'b0; lt_rw_n = 1'b0;
        @(negedge clk);
        lt_cs_n = 1'b1; lt_rw_n = 1'b1;
        rt_addr = TOP; rt_cs_n = 1'b0; rt_rw_n = 1'b1; rt_oe_n = 1'b0;
        @(negedge clk);
        rt_cs_n = 1'b1; rt_oe_n = 1'b1;
        check(rt_irq_n, 1'b0, "R8", "set and clear same edge");
        rt_read(TOP, 1'b0);
        check(rt_irq_n, 1'b1, "R8", "later clear still works");
    endtask

    task automatic t_addr_move_R9();
        @(negedge clk);
        lt_addr = TOP; lt_cs_n = 1'b0; lt_rw_n = 1'b0;
        @(negedge clk);
        lt_addr = 15'h0040;
        @(negedge clk);
        lt_cs_n = 1'b1; lt_rw_n = 1'b1;
        @(negedge clk);
        check(rt_irq_n, 1'b1, "R9", "write moved off top");
        @(negedge clk);
        lt_addr = 15'h0040; lt_cs_n = 1'b0; lt_rw_n = 1'b0;
        @(negedge clk);
        lt_addr = TOP;
        @(negedge clk);
        lt_cs_n = 1'b1; lt_rw_n = 1'b1;
        @(negedge clk);
        check(rt_irq_n, 1'b0, "R9", "write moved onto top");
        rt_read(TOP, 1'b0);
    endtask

    task automatic t_wide_R10();
        @(negedge clk);
        w_lt_addr = 16'h7FFF; w_lt_cs_n = 1'b0; w_lt_rw_n = 1'b0;
        @(negedge clk);
        w_lt_cs_n = 1'b1; w_lt_rw_n = 1'b1;
        @(negedge clk);
        check(w_rt_irq_n, 1'b1, "R10", "wide: write 7FFF ignored");
        w_lt_addr = 16'hFFFF; w_lt_cs_n = 1'b0; w_lt_rw_n = 1'b0;
        @(negedge clk);
        w_lt_cs_n = 1'b1; w_lt_rw_n = 1'b1;
        @(negedge clk);
        check(w_rt_irq_n, 1'b0, "R10", "wide: write FFFF raises");
        w_rt_addr = 16'hFFFE; w_rt_cs_n = 1'b0; w_rt_rw_n = 1'b0;
        @(negedge clk);
        w_rt_cs_n = 1'b1; w_rt_rw_n = 1'b1;
        @(negedge clk);
        check(w_lt_irq_n, 1'b0, "R10", "wide: write FFFE raises left");
        w_rt_addr = 16'hFFFF; w_rt_cs_n = 1'b0; w_rt_rw_n = 1'b1; w_rt_oe_n = 1'b0;
        @(negedge clk);
        w_rt_cs_n = 1'b1; w_rt_oe_n = 1'b1;
        check(w_rt_irq_n, 1'b1, "R10", "wide: read FFFF clears");
    endtask

    initial begin
        t_reset_R1();
        t_left_raise_R2();
        t_bad_reads_R6();
        t_right_clear_R3();
        t_left_path_R4_R5();
        t_owner_writes_R7();
        t_set_wins_R8();
        t_addr_move_R9();
        t_wide_R10();
        repeat (2) @(negedge clk);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

endmodule